// File: doc/BRIEF.md
# Self-Calibrating Periodic Wake-Up Timer

This block raises a periodic wake event for a low-power system. It keeps time with a cheap, drifting low-frequency oscillator and corrects that oscillator against the accurate crystal clock. Before the first wake event, and again after a programmed number of corrected milliseconds, it measures how many crystal cycles fit into a fixed number of slow-oscillator cycles. Each slow tick then adds that measurement to a fractional accumulator. A corrected millisecond is counted every time the accumulator passes the number of crystal cycles in one millisecond, so the wake period follows crystal time and not the slow oscillator's own rate.

The crystal may be switched off to save power. The block raises a crystal request only for the length of one calibration. It waits for the crystal-ready input, measures, and then drops the request. The wake period is written as mantissa × 2^exponent milliseconds, which covers single milliseconds and also spans of hours. Both oscillators reach the block as one-cycle strobes in a common sampling clock, so the block has no clock-domain crossing. The block has no data stream, so every pin is plain control or status with no valid/ready handshake.

Top module: `wake_timer`

## Requirements
- R1: While reset is held, and on the first cycle after it, `wake_o` and `xtal_req_o` are low.
- R2: `xtal_req_o` goes high on the clock edge after `en_i` is seen high. `wake_o` stays low until the first calibration has finished.
- R3: While `xtal_rdy_i` stays low, `xtal_req_o` remains high and no measurement starts, however long the wait is.
- R4: After `xtal_rdy_i` rises, the block waits for the next slow tick. It then counts crystal strobes until CAL_SLOW more slow ticks have passed, and drops `xtal_req_o`. This takes between CAL_SLOW and CAL_SLOW+1 slow-tick periods.
- R5: The distance between consecutive `wake_o` pulses is per_mant_i × 2^per_exp_i milliseconds of crystal time, where one millisecond is XTAL_PER_MS crystal strobes. This holds for any slow-tick rate at which that span is a whole number of slow ticks.
- R6: With `autocal_en_i` high, a new calibration starts (`xtal_req_o` rises) after every CAL_IVL_MS corrected milliseconds. Wake spacing is not disturbed while it runs.
- R7: With `autocal_en_i` low, `xtal_req_o` does not rise again after the startup calibration.
- R8: per_mant_i equal to 0 stops wake events and clears the period count.
- R9: `wake_o` is high for exactly one clock cycle per event.
- R10: With `en_i` low, both outputs are low from the next cycle on, and the calibration is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock shared by all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Timer enable; a rising level starts the startup calibration |
| autocal_en_i | input | 1 | Allows the periodic recalibration |
| slow_tick_i | input | 1 | One-cycle strobe per slow-oscillator period |
| xtal_tick_i | input | 1 | One-cycle strobe per crystal period |
| xtal_rdy_i | input | 1 | Crystal running and stable |
| per_mant_i | input | MW | Period mantissa in milliseconds |
| per_exp_i | input | RW | Period exponent (power of two) |
| wake_o | output | 1 | Single-cycle wake event |
| xtal_req_o | output | 1 | Request to power the crystal for calibration |

## Verification
The properties assume that slow strobes never come on two consecutive cycles. They also assume that `xtal_rdy_i`, once high during a request, stays high until `xtal_req_o` falls. The bench's crystal model keeps ready up until the request drops, and it spaces slow strobes 20 or 40 cycles apart. Crystal strobes fall on odd cycles and slow strobes on even ones, so each measurement window holds an exactly known crystal count. Settings are changed only while the timer is disabled, or by passing through a zero mantissa, so every compared interval comes from a settled count.

// File: rtl/wake_timer_pkg.sv
`timescale 1ns/1ps
package wake_timer_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_REQ   = 3'd1,
    ST_ALIGN = 3'd2,
    ST_MEAS  = 3'd3,
    ST_RUN   = 3'd4
  } cal_st_t;
endpackage

// File: rtl/wake_timer_cal.sv
`timescale 1ns/1ps
module wake_timer_cal
  import wake_timer_pkg::*;
#(
  parameter int CAL_SLOW   = 8,
  parameter int FULL       = 200,
  parameter int FW         = 8,
  parameter int CAL_IVL_MS = 40000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          autocal_i,
  input  logic          slow_tick_i,
  input  logic          xtal_tick_i,
  input  logic          xtal_rdy_i,
  input  logic          ms_tick_i,
  output logic [FW-1:0] factor_o,
  output logic          vld_o,
  output logic          req_o
);
  localparam int SW = (CAL_SLOW > 1) ? $clog2(CAL_SLOW) : 1;
  localparam int IW = $clog2(CAL_IVL_MS + 1);
  localparam logic [FW-1:0] FULL_V = FW'(FULL);
  localparam logic [SW-1:0] SLOW_LAST = SW'(CAL_SLOW - 1);
  localparam logic [IW-1:0] IVL_LAST = IW'(CAL_IVL_MS - 1);

  cal_st_t       st;
  logic [SW-1:0] slow_cnt;
  logic [FW-1:0] xcnt, xnext;
  logic [IW-1:0] ivl_cnt;

  // crystal count including a strobe arriving in this cycle, saturated
  always_comb begin
    xnext = xcnt;
    if (xtal_tick_i && xcnt < FULL_V) xnext = xcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_OFF;
      slow_cnt <= '0;
      xcnt     <= '0;
      ivl_cnt  <= '0;
      factor_o <= '0;
      vld_o    <= 1'b0;
    end else if (!en_i) begin
      st       <= ST_OFF;
      slow_cnt <= '0;
      xcnt     <= '0;
      ivl_cnt  <= '0;
      factor_o <= '0;
      vld_o    <= 1'b0;
    end else begin
      case (st)
        ST_OFF:   st <= ST_REQ;
        ST_REQ:   if (xtal_rdy_i) st <= ST_ALIGN;
        ST_ALIGN: if (slow_tick_i) begin
          st       <= ST_MEAS;
          slow_cnt <= '0;
          xcnt     <= '0;
        end
        ST_MEAS: begin
          xcnt <= xnext;
          if (slow_tick_i) begin
            if (slow_cnt == SLOW_LAST) begin
              factor_o <= xnext;
              vld_o    <= 1'b1;
              ivl_cnt  <= '0;
              st       <= ST_RUN;
            end else begin
              slow_cnt <= slow_cnt + 1'b1;
            end
          end
        end
        ST_RUN: if (ms_tick_i) begin
          if (autocal_i && ivl_cnt == IVL_LAST) begin
            ivl_cnt <= '0;
            st      <= ST_REQ;
          end else if (ivl_cnt != IVL_LAST) begin
            ivl_cnt <= ivl_cnt + 1'b1;
          end
        end
        default: st <= ST_OFF;
      endcase
    end
  end

  assign req_o = (st == ST_REQ) || (st == ST_ALIGN) || (st == ST_MEAS);
endmodule

// File: rtl/wake_timer_msgen.sv
`timescale 1ns/1ps
module wake_timer_msgen #(
  parameter int FULL = 200,
  parameter int FW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          vld_i,
  input  logic          slow_tick_i,
  input  logic [FW-1:0] factor_i,
  output logic          ms_tick_o
);
  localparam logic [FW:0] FULL_V = (FW+1)'(FULL);

  logic [FW-1:0] acc;
  logic [FW:0]   sum;

  assign sum = {1'b0, acc} + {1'b0, factor_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      ms_tick_o <= 1'b0;
    end else if (!en_i || !vld_i) begin
      acc       <= '0;
      ms_tick_o <= 1'b0;
    end else begin
      ms_tick_o <= 1'b0;
      if (slow_tick_i) begin
        if (sum >= FULL_V) begin
          acc       <= FW'(sum - FULL_V);
          ms_tick_o <= 1'b1;
        end else begin
          acc <= sum[FW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/wake_timer_period.sv
`timescale 1ns/1ps
module wake_timer_period #(
  parameter int MW = 8,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          ms_tick_i,
  input  logic [MW-1:0] mant_i,
  input  logic [RW-1:0] exp_i,
  output logic          wake_o
);
  localparam int TW = MW + (1 << RW) - 1;

  logic [TW-1:0] target, cnt;
  logic [TW:0]   cnt_nx;

  assign target = TW'(mant_i) << exp_i;
  assign cnt_nx = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      wake_o <= 1'b0;
    end else if (!en_i || mant_i == '0) begin
      cnt    <= '0;
      wake_o <= 1'b0;
    end else begin
      wake_o <= 1'b0;
      if (ms_tick_i) begin
        if (cnt_nx >= {1'b0, target}) begin
          cnt    <= '0;
          wake_o <= 1'b1;
        end else begin
          cnt <= cnt_nx[TW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/wake_timer.sv
`timescale 1ns/1ps
module wake_timer #(
  parameter int CAL_SLOW    = 8,
  parameter int XTAL_PER_MS = 10000,
  parameter int CAL_IVL_MS  = 40000,
  parameter int MW          = 8,
  parameter int RW          = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          autocal_en_i,
  input  logic          slow_tick_i,
  input  logic          xtal_tick_i,
  input  logic          xtal_rdy_i,
  input  logic [MW-1:0] per_mant_i,
  input  logic [RW-1:0] per_exp_i,
  output logic          wake_o,
  output logic          xtal_req_o
);
  localparam int FULL = CAL_SLOW * XTAL_PER_MS;
  localparam int FW   = $clog2(FULL + 1);

  logic [FW-1:0] factor;
  logic          cal_vld;
  logic          ms_tick;

  wake_timer_cal #(
    .CAL_SLOW(CAL_SLOW), .FULL(FULL), .FW(FW), .CAL_IVL_MS(CAL_IVL_MS)
  ) u_cal (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .autocal_i(autocal_en_i),
    .slow_tick_i(slow_tick_i), .xtal_tick_i(xtal_tick_i),
    .xtal_rdy_i(xtal_rdy_i), .ms_tick_i(ms_tick),
    .factor_o(factor), .vld_o(cal_vld), .req_o(xtal_req_o)
  );

  wake_timer_msgen #(.FULL(FULL), .FW(FW)) u_msgen (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .vld_i(cal_vld),
    .slow_tick_i(slow_tick_i), .factor_i(factor), .ms_tick_o(ms_tick)
  );

  wake_timer_period #(.MW(MW), .RW(RW)) u_period (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .ms_tick_i(ms_tick),
    .mant_i(per_mant_i), .exp_i(per_exp_i), .wake_o(wake_o)
  );
endmodule

// File: rtl/wake_timer_chk.sv
`timescale 1ns/1ps
module wake_timer_chk #(
  parameter int MW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_i,
  input logic          autocal_en_i,
  input logic          xtal_rdy_i,
  input logic [MW-1:0] per_mant_i,
  input logic          wake_o,
  input logic          xtal_req_o,
  input logic          cal_vld
);
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o); // R9

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xtal_req_o) |-> $past(en_i)); // R2

  AST_NO_WAKE_UNCAL: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_vld |-> !wake_o); // R2

  AST_REQ_WAITS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && xtal_req_o && !xtal_rdy_i) |=> xtal_req_o); // R3

  AST_MANT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(per_mant_i) == '0) |-> !wake_o); // R8

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> (!wake_o && !xtal_req_o)); // R10

  AST_RECAL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(xtal_req_o) && $past(cal_vld)) |-> $past(autocal_en_i)); // R7
endmodule

bind wake_timer wake_timer_chk #(.MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .autocal_en_i(autocal_en_i),
  .xtal_rdy_i(xtal_rdy_i), .per_mant_i(per_mant_i), .wake_o(wake_o),
  .xtal_req_o(xtal_req_o), .cal_vld(cal_vld)
);

// File: tb/wake_timer_tb.sv
`timescale 1ns/1ps
module wake_timer_tb;
  localparam int CAL_SLOW = 8;
  localparam int XPM      = 25;
  localparam int IVL      = 12;
  localparam int MW       = 4;
  localparam int RW       = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, en_i, autocal_en_i, slow_tick_i, xtal_tick_i, xtal_rdy_i;
  logic [MW-1:0] per_mant_i;
  logic [RW-1:0] per_exp_i;
  logic          wake_o, xtal_req_o;

  wake_timer #(
    .CAL_SLOW(CAL_SLOW), .XTAL_PER_MS(XPM), .CAL_IVL_MS(IVL), .MW(MW), .RW(RW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .autocal_en_i(autocal_en_i),
    .slow_tick_i(slow_tick_i), .xtal_tick_i(xtal_tick_i), .xtal_rdy_i(xtal_rdy_i),
    .per_mant_i(per_mant_i), .per_exp_i(per_exp_i),
    .wake_o(wake_o), .xtal_req_o(xtal_req_o)
  );

  int    n_chk = 0, n_fail = 0;
  int    ps = 20;
  bit    hold_rdy = 1'b1;
  int    rdy_wait = 0;
  int    cyc = 0;
  int    mcyc = 0;
  int    nwake = 0, nreq = 0;
  int    last_wake = 0;
  bit    skip_one = 1'b1;
  bit    prev_wake = 1'b0, prev_req = 1'b0;
  int    sb_q[$];
  string cur_tag = "R5";

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // oscillator and crystal models
  initial begin
    slow_tick_i = 1'b0;
    xtal_tick_i = 1'b0;
    xtal_rdy_i  = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      slow_tick_i = (cyc % ps == 0);
      xtal_tick_i = xtal_rdy_i && (cyc % 2 == 1);
      if (xtal_req_o && !xtal_rdy_i && !hold_rdy) begin
        if (rdy_wait >= 30) xtal_rdy_i = 1'b1;
        else rdy_wait++;
      end else if (!xtal_req_o && xtal_rdy_i) begin
        xtal_rdy_i = 1'b0;
        rdy_wait   = 0;
      end
    end
  end

  // monitor: pops expected wake spacing from the scoreboard
  always @(negedge clk) begin
    mcyc++;
    if (xtal_req_o && !prev_req) nreq++;
    prev_req = xtal_req_o;
    if (wake_o) begin
      nwake++;
      check(!prev_wake, "R9", 2, 1);
      if (skip_one) skip_one = 1'b0;
      else if (sb_q.size() > 0) begin
        int e;
        e = sb_q.pop_front();
        check(mcyc - last_wake == e, cur_tag, mcyc - last_wake, e);
      end
      last_wake = mcyc;
    end
    prev_wake = wake_o;
  end

  task automatic expect_intervals(input int n, input int iv, input string tag);
    cur_tag  = tag;
    skip_one = 1'b1;
    for (int i = 0; i < n; i++) sb_q.push_back(iv);
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic restart(input int new_ps, input int m, input int e);
    @(negedge clk);
    en_i = 1'b0;
    repeat (3) @(negedge clk);
    ps = new_ps;
    per_mant_i = MW'(m);
    per_exp_i  = RW'(e);
    en_i = 1'b1;
  endtask

  initial begin
    int k, snap;
    rst_n = 1'b0; en_i = 1'b0; autocal_en_i = 1'b1;
    per_mant_i = MW'(2); per_exp_i = RW'(1);
    repeat (10) @(negedge clk);
    check(!wake_o && !xtal_req_o, "R1", {wake_o, xtal_req_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!wake_o && !xtal_req_o, "R1", {wake_o, xtal_req_o}, 0);

    en_i = 1'b1;
    @(negedge clk);
    check(xtal_req_o == 1'b1, "R2", xtal_req_o, 1);

    repeat (300) @(negedge clk);
    check(xtal_req_o == 1'b1, "R3", xtal_req_o, 1);
    check(nwake == 0, "R3", nwake, 0);

    hold_rdy = 1'b0;
    while (!xtal_rdy_i) @(negedge clk);
    k = 0;
    while (xtal_req_o && k < 1000) begin
      @(negedge clk);
      k++;
    end
    check(k >= CAL_SLOW * 20 && k <= (CAL_SLOW + 1) * 20 + 2, "R4", k, CAL_SLOW * 20);
    check(nwake == 0, "R2", nwake, 0);

    // 4 ms at 2.5 slow ticks per ms
    expect_intervals(4, 200, "R5");

    // periodic recalibration while wakes keep their spacing
    snap = nreq;
    expect_intervals(12, 200, "R6");
    check(nreq - snap >= 2, "R6", nreq - snap, 2);

    // autocalibration off
    autocal_en_i = 1'b0;
    while (xtal_req_o) @(negedge clk);
    snap = nreq;
    expect_intervals(12, 200, "R7");
    check(nreq - snap == 0, "R7", nreq - snap, 0);

    // disable: outputs quiet
    @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    check(!xtal_req_o && !wake_o, "R10", {wake_o, xtal_req_o}, 0);
    snap = nwake;
    repeat (300) @(negedge clk);
    check(nwake == snap && !xtal_req_o, "R10", nwake - snap, 0);

    // 12 ms period, same slow rate
    autocal_en_i = 1'b1;
    restart(20, 3, 2);
    expect_intervals(3, 600, "R5");

    // slower oscillator, recalibrated: still 4 ms of crystal time
    restart(40, 2, 1);
    expect_intervals(4, 200, "R5");

    // zero mantissa stops wakes
    @(negedge clk);
    per_mant_i = '0;
    @(negedge clk);
    snap = nwake;
    repeat (2000) @(negedge clk);
    check(nwake == snap, "R8", nwake - snap, 0);
    per_mant_i = MW'(1); per_exp_i = RW'(2);
    expect_intervals(3, 200, "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule